// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Flags

This block is a purely combinational arithmetic and logic unit for an 8-bit accumulator datapath. It receives the accumulator value, a second operand, the current carry and auxiliary-carry flags, and a 4-bit operation code. It returns the 8-bit result, a packed flag byte, and a write mask that tells the surrounding datapath which flag bits this operation updates. A separate result-write strobe tells the datapath whether the accumulator should take the result.

The datapath merges the flag byte into its flag register under the write mask. Any flag that is outside the mask keeps its previous value. The supported operations are:

- arithmetic: add and subtract, each with and without carry, plus compare, increment and decrement;
- logic: AND, OR and XOR;
- rotates: four variants, with and without the carry;
- decimal adjust after BCD addition.

Top module: `alu8_core`

## Requirements
- R1: The flag byte holds S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bits 5, 3 and 1 of both the flag byte and the write mask are always 0. Every flag bit whose mask bit is 0 reads 0.
- R2: The operation codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 increment, 6 decrement, 7 AND, 8 OR, 9 XOR, 10 rotate left, 11 rotate left through carry, 12 rotate right, 13 rotate right through carry, 14 decimal adjust. Code 15 is idle: the result equals the accumulator, the mask is 0 and the write strobe is low.
- R3: Wherever S, Z and P are written, S equals bit 7 of the computed value, Z is 1 when that value is zero, and P is 1 when it has an even number of ones.
- R4: Add produces A+B. Add with carry produces A+B+cy_i. CY is the carry out of bit 7 and AC is the carry out of bit 3.
- R5: Subtract produces A−B and subtract with borrow produces A−B−cy_i. Both are computed as A + ~B + (1 or NOT cy_i). CY is set on a borrow, that is when the subtrahend exceeds A. AC is the carry out of bit 3 of that sum.
- R6: Compare writes flags exactly as subtract would. The result output equals the accumulator and the write strobe is low.
- R7: Increment and decrement write S, Z, AC and P but never CY (mask D4h). AC is set on increment when the low nibble is Fh, and on decrement when the low nibble is not 0.
- R8: AND writes S, Z and P from the result, clears CY and sets AC.
- R9: OR and XOR write S, Z and P from the result and clear both CY and AC.
- R10: Rotates write only CY (mask 01h). Rotate left moves bit 7 into bit 0 and into CY. Rotate left through carry moves cy_i into bit 0 and bit 7 into CY. Rotate right moves bit 0 into bit 7 and into CY. Rotate right through carry moves cy_i into bit 7 and bit 0 into CY.
- R11: Decimal adjust first adds 06h when the low nibble exceeds 9 or ac_i is 1; AC is the carry out of bit 3 of that step. It then adds 60h when the new high nibble exceeds 9, when cy_i is 1, or when the first step carried out of bit 7. CY is set exactly when this second correction is applied.
- R12: The write mask is D5h for add, subtract, compare, the logic operations and decimal adjust. The write strobe is high for every code except compare and the idle code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary carry flag |
| op_i | input | 4 | Operation code |
| res_o | output | 8 | Result value |
| flags_o | output | 8 | Packed flag byte |
| wmask_o | output | 8 | Flags written by this operation |
| res_we_o | output | 1 | Accumulator write strobe |

## Verification
The block holds no state, so any fault appears on the outputs in the same evaluation as the input that exposes it. The faults to look for are a wrong carry polarity on subtract, a wrong operand or carry-in selection, or a mis-decoded mask. Each would show as a wrong flag bit or mask bit for one operation code and one operand pattern. Borrow-versus-carry and nibble-boundary faults only appear at specific operand values, so the vectors sit on those edges: FFh+1, equal operands, a subtrahend larger than the accumulator, and nibble values of 0, 9 and Fh. Sweeps over every accumulator value catch a compare that writes the accumulator, or an increment that touches CY.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam int BCD_MAX = 9;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_CMP = 4'd4, OP_INC = 4'd5, OP_DEC = 4'd6, OP_AND = 4'd7,
    OP_OR  = 4'd8, OP_XOR = 4'd9, OP_RLC = 4'd10, OP_RAL = 4'd11,
    OP_RRC = 4'd12, OP_RAR = 4'd13, OP_DAA = 4'd14, OP_NOP = 4'd15
  } alu_op_e;

  localparam int FB_CY = 0;
  localparam int FB_P  = 2;
  localparam int FB_AC = 4;
  localparam int FB_Z  = 6;
  localparam int FB_S  = 7;

  localparam logic [DW-1:0] MSK_ALL   = 8'hD5;
  localparam logic [DW-1:0] MSK_NOCY  = 8'hD4;
  localparam logic [DW-1:0] MSK_CY    = 8'h01;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder
  import alu8_pkg::*;
(
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          ci_i,
  output logic [DW-1:0] sum_o,
  output logic          c_full_o,
  output logic          c_half_o
);
  localparam int HW = DW - NW;

  logic [NW:0] lo_sum;
  logic [HW:0] hi_sum;

  always_comb begin
    lo_sum = {1'b0, x_i[NW-1:0]} + {1'b0, y_i[NW-1:0]} + {{NW{1'b0}}, ci_i};
    hi_sum = {1'b0, x_i[DW-1:NW]} + {1'b0, y_i[DW-1:NW]} + {{HW{1'b0}}, lo_sum[NW]};
  end

  assign sum_o    = {hi_sum[HW-1:0], lo_sum[NW-1:0]};
  assign c_full_o = hi_sum[HW];
  assign c_half_o = lo_sum[NW];
endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o
);
  logic [DW-1:0] y_sel;
  logic          ci_sel;
  logic          c_full;
  logic          is_sub;

  always_comb begin
    y_sel  = b_i;
    ci_sel = 1'b0;
    is_sub = 1'b0;
    case (op_i)
      OP_ADC: ci_sel = cy_i;
      OP_SUB, OP_CMP: begin
        y_sel  = ~b_i;
        ci_sel = 1'b1;
        is_sub = 1'b1;
      end
      OP_SBB: begin
        y_sel  = ~b_i;
        ci_sel = ~cy_i;
        is_sub = 1'b1;
      end
      OP_INC: begin
        y_sel  = '0;
        ci_sel = 1'b1;
      end
      OP_DEC: y_sel = '1;
      default: ;
    endcase
  end

  alu8_adder u_add (
    .x_i      (a_i),
    .y_i      (y_sel),
    .ci_i     (ci_sel),
    .sum_o    (res_o),
    .c_full_o (c_full),
    .c_half_o (ac_o)
  );

  assign cy_o = is_sub ? ~c_full : c_full;
endmodule

// File: rtl/alu8_logic_rot.sv
module alu8_logic_rot
  import alu8_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o
);
  always_comb begin
    res_o = a_i;
    cy_o  = 1'b0;
    ac_o  = 1'b0;
    case (op_i)
      OP_AND: begin
        res_o = a_i & b_i;
        ac_o  = 1'b1;
      end
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_RLC: begin
        res_o = {a_i[DW-2:0], a_i[DW-1]};
        cy_o  = a_i[DW-1];
      end
      OP_RAL: begin
        res_o = {a_i[DW-2:0], cy_i};
        cy_o  = a_i[DW-1];
      end
      OP_RRC: begin
        res_o = {a_i[0], a_i[DW-1:1]};
        cy_o  = a_i[0];
      end
      OP_RAR: begin
        res_o = {cy_i, a_i[DW-1:1]};
        cy_o  = a_i[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic          cy_i,
  input  logic          ac_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o
);
  localparam logic [DW-1:0] LO_FIX = DW'(6);
  localparam logic [DW-1:0] HI_FIX = DW'(6) << NW;

  logic          lo_need;
  logic          hi_need;
  logic [NW:0]   lo_step;
  logic [DW:0]   mid;

  always_comb begin
    lo_need = (a_i[NW-1:0] > NW'(BCD_MAX)) || ac_i;
    lo_step = {1'b0, a_i[NW-1:0]} + (lo_need ? (NW+1)'(6) : '0);
    mid     = {1'b0, a_i} + {1'b0, (lo_need ? LO_FIX : '0)};
    hi_need = (mid[DW-1:NW] > (DW-NW)'(BCD_MAX)) || cy_i || mid[DW];
    res_o   = mid[DW-1:0] + (hi_need ? HI_FIX : '0);
    cy_o    = hi_need;
    ac_o    = lo_step[NW];
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic [DW-1:0] val_i,
  input  logic          cy_i,
  input  logic          ac_i,
  input  logic [DW-1:0] mask_i,
  output logic [DW-1:0] flags_o
);
  logic [DW-1:0] raw;

  always_comb begin
    raw        = '0;
    raw[FB_S]  = val_i[DW-1];
    raw[FB_Z]  = (val_i == '0);
    raw[FB_AC] = ac_i;
    raw[FB_P]  = ~^val_i;
    raw[FB_CY] = cy_i;
  end

  assign flags_o = raw & mask_i;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  input  logic       cy_i,
  input  logic       ac_i,
  input  logic [3:0] op_i,
  output logic [7:0] res_o,
  output logic [7:0] flags_o,
  output logic [7:0] wmask_o,
  output logic       res_we_o
);
  alu_op_e       op;
  logic [DW-1:0] ar_res, lr_res, da_res;
  logic          ar_cy, ar_ac, lr_cy, lr_ac, da_cy, da_ac;
  logic [DW-1:0] val;
  logic          sel_cy, sel_ac;

  assign op = alu_op_e'(op_i);

  alu8_arith u_arith (
    .op_i (op), .a_i (a_i), .b_i (b_i), .cy_i (cy_i),
    .res_o (ar_res), .cy_o (ar_cy), .ac_o (ar_ac)
  );

  alu8_logic_rot u_lrot (
    .op_i (op), .a_i (a_i), .b_i (b_i), .cy_i (cy_i),
    .res_o (lr_res), .cy_o (lr_cy), .ac_o (lr_ac)
  );

  alu8_daa u_daa (
    .a_i (a_i), .cy_i (cy_i), .ac_i (ac_i),
    .res_o (da_res), .cy_o (da_cy), .ac_o (da_ac)
  );

  always_comb begin
    val      = a_i;
    sel_cy   = 1'b0;
    sel_ac   = 1'b0;
    wmask_o  = MSK_ALL;
    res_we_o = 1'b1;
    res_o    = a_i;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        val = ar_res; sel_cy = ar_cy; sel_ac = ar_ac; res_o = ar_res;
      end
      OP_CMP: begin
        val = ar_res; sel_cy = ar_cy; sel_ac = ar_ac; res_we_o = 1'b0;
      end
      OP_INC, OP_DEC: begin
        val = ar_res; sel_ac = ar_ac; res_o = ar_res; wmask_o = MSK_NOCY;
      end
      OP_AND, OP_OR, OP_XOR: begin
        val = lr_res; sel_cy = lr_cy; sel_ac = lr_ac; res_o = lr_res;
      end
      OP_RLC, OP_RAL, OP_RRC, OP_RAR: begin
        val = lr_res; sel_cy = lr_cy; res_o = lr_res; wmask_o = MSK_CY;
      end
      OP_DAA: begin
        val = da_res; sel_cy = da_cy; sel_ac = da_ac; res_o = da_res;
      end
      default: begin
        wmask_o  = '0;
        res_we_o = 1'b0;
      end
    endcase
  end

  alu8_flags u_flags (
    .val_i (val), .cy_i (sel_cy), .ac_i (sel_ac),
    .mask_i (wmask_o), .flags_o (flags_o)
  );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
  input logic [7:0] a_i,
  input logic [7:0] b_i,
  input logic       cy_i,
  input logic       ac_i,
  input logic [3:0] op_i,
  input logic [7:0] res_o,
  input logic [7:0] flags_o,
  input logic [7:0] wmask_o,
  input logic       res_we_o
);
  always_comb begin
    AST_UNUSED_BITS_LOW: assert ((flags_o & 8'h2A) == 8'h00 && (wmask_o & 8'h2A) == 8'h00); // R1
    AST_FLAGS_WITHIN_MASK: assert ((flags_o & ~wmask_o) == 8'h00); // R1
    AST_IDLE_CODE_QUIET: assert (op_i != 4'd15 || (wmask_o == 8'h00 && !res_we_o && res_o == a_i)); // R2
    AST_ZERO_FOLLOWS_RESULT: assert (!(res_we_o && wmask_o[6]) || flags_o[6] == (res_o == 8'h00)); // R3
    AST_CMP_KEEPS_ACC: assert (op_i != 4'd4 || (res_o == a_i && !res_we_o)); // R6
    AST_INCDEC_NO_CY: assert (!(op_i == 4'd5 || op_i == 4'd6) || !wmask_o[0]); // R7
    AST_AND_AC_SET: assert (op_i != 4'd7 || (flags_o[4] && !flags_o[0])); // R8
    AST_ROTATE_CY_ONLY: assert (!(op_i >= 4'd10 && op_i <= 4'd13) || wmask_o == 8'h01); // R10
  end
endmodule

bind alu8_core alu8_core_chk u_chk (
  .a_i (a_i), .b_i (b_i), .cy_i (cy_i), .ac_i (ac_i), .op_i (op_i),
  .res_o (res_o), .flags_o (flags_o), .wmask_o (wmask_o), .res_we_o (res_we_o)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  typedef struct packed {
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic       cy;
    logic       ac;
    logic [7:0] res;
    logic [7:0] flg;
    logic [7:0] msk;
    logic       we;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h44, 8'hD5, 1'b1, 4'd3},  // R3 zero, even parity
    '{4'd0,  8'h70, 8'h10, 1'b0, 1'b0, 8'h80, 8'h80, 8'hD5, 1'b1, 4'd3},  // R3 sign
    '{4'd0,  8'h10, 8'h10, 1'b0, 1'b0, 8'h20, 8'h00, 8'hD5, 1'b1, 4'd4},  // R4
    '{4'd0,  8'h12, 8'h39, 1'b0, 1'b0, 8'h4B, 8'h04, 8'hD5, 1'b1, 4'd4},  // R4
    '{4'd0,  8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 8'h55, 8'hD5, 1'b1, 4'd4},  // R4 wrap
    '{4'd1,  8'h10, 8'h10, 1'b1, 1'b0, 8'h21, 8'h04, 8'hD5, 1'b1, 4'd4},  // R4 carry in
    '{4'd1,  8'h0F, 8'h00, 1'b1, 1'b0, 8'h10, 8'h10, 8'hD5, 1'b1, 4'd4},  // R4 half carry
    '{4'd2,  8'h20, 8'h10, 1'b0, 1'b0, 8'h10, 8'h10, 8'hD5, 1'b1, 4'd5},  // R5
    '{4'd2,  8'h10, 8'h20, 1'b0, 1'b0, 8'hF0, 8'h95, 8'hD5, 1'b1, 4'd5},  // R5 borrow
    '{4'd3,  8'h20, 8'h0F, 1'b1, 1'b0, 8'h10, 8'h00, 8'hD5, 1'b1, 4'd5},  // R5
    '{4'd3,  8'h05, 8'h05, 1'b1, 1'b0, 8'hFF, 8'h85, 8'hD5, 1'b1, 4'd5},  // R5 borrow in
    '{4'd4,  8'h17, 8'h17, 1'b0, 1'b0, 8'h17, 8'h54, 8'hD5, 1'b0, 4'd6},  // R6 equal
    '{4'd4,  8'h10, 8'h17, 1'b0, 1'b0, 8'h10, 8'h85, 8'hD5, 1'b0, 4'd6},  // R6 less
    '{4'd5,  8'h0F, 8'h00, 1'b1, 1'b0, 8'h10, 8'h10, 8'hD4, 1'b1, 4'd7},  // R7
    '{4'd5,  8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 8'h54, 8'hD4, 1'b1, 4'd7},  // R7
    '{4'd6,  8'h10, 8'h00, 1'b1, 1'b0, 8'h0F, 8'h04, 8'hD4, 1'b1, 4'd7},  // R7
    '{4'd6,  8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 8'h84, 8'hD4, 1'b1, 4'd7},  // R7
    '{4'd7,  8'h10, 8'h10, 1'b1, 1'b0, 8'h10, 8'h10, 8'hD5, 1'b1, 4'd8},  // R8
    '{4'd7,  8'hF0, 8'h0F, 1'b0, 1'b0, 8'h00, 8'h54, 8'hD5, 1'b1, 4'd8},  // R8
    '{4'd8,  8'h10, 8'h17, 1'b1, 1'b1, 8'h17, 8'h04, 8'hD5, 1'b1, 4'd9},  // R9
    '{4'd9,  8'h10, 8'h17, 1'b0, 1'b1, 8'h07, 8'h00, 8'hD5, 1'b1, 4'd9},  // R9
    '{4'd9,  8'h80, 8'h00, 1'b1, 1'b0, 8'h80, 8'h80, 8'hD5, 1'b1, 4'd9},  // R9
    '{4'd10, 8'h03, 8'h00, 1'b0, 1'b0, 8'h06, 8'h00, 8'h01, 1'b1, 4'd10}, // R10
    '{4'd10, 8'h81, 8'h00, 1'b0, 1'b1, 8'h03, 8'h01, 8'h01, 1'b1, 4'd10}, // R10
    '{4'd11, 8'h03, 8'h00, 1'b1, 1'b0, 8'h07, 8'h00, 8'h01, 1'b1, 4'd10}, // R10
    '{4'd11, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 8'h01, 8'h01, 1'b1, 4'd10}, // R10
    '{4'd12, 8'h03, 8'h00, 1'b0, 1'b0, 8'h81, 8'h01, 8'h01, 1'b1, 4'd10}, // R10
    '{4'd13, 8'h02, 8'h00, 1'b1, 1'b0, 8'h81, 8'h00, 8'h01, 1'b1, 4'd10}, // R10
    '{4'd13, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 8'h01, 8'h01, 1'b1, 4'd10}, // R10
    '{4'd14, 8'h4B, 8'h00, 1'b0, 1'b0, 8'h51, 8'h10, 8'hD5, 1'b1, 4'd11}, // R11
    '{4'd14, 8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 8'h55, 8'hD5, 1'b1, 4'd11}, // R11
    '{4'd14, 8'h02, 8'h00, 1'b0, 1'b1, 8'h08, 8'h00, 8'hD5, 1'b1, 4'd11}, // R11
    '{4'd14, 8'h15, 8'h00, 1'b1, 1'b0, 8'h75, 8'h01, 8'hD5, 1'b1, 4'd11}, // R11
    '{4'd15, 8'h5A, 8'h33, 1'b1, 1'b1, 8'h5A, 8'h00, 8'h00, 1'b0, 4'd2}   // R2
  };

  logic       clk;
  logic       rst_n;
  logic [7:0] a, b;
  logic       cy, ac;
  logic [3:0] op;
  logic [7:0] res, flg, msk;
  logic       we;
  int         n_chk;
  int         n_err;
  bit         done;

  alu8_core u_dut (
    .a_i (a), .b_i (b), .cy_i (cy), .ac_i (ac), .op_i (op),
    .res_o (res), .flags_o (flg), .wmask_o (msk), .res_we_o (we)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic drive(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic c, input logic h);
    @(negedge clk);
    op = o; a = x; b = y; cy = c; ac = h;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; op = 4'd0; a = '0; b = '0; cy = 1'b0; ac = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 R3: state straight after reset with zero inputs (add 0+0)
    check("R1 reset flags", {24'd0, flg}, 32'h44);
    check("R12 reset mask", {24'd0, msk}, 32'hD5);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].cy, VECS[i].ac);
      check($sformatf("R%0d vec%0d res", VECS[i].req, i), {24'd0, res}, {24'd0, VECS[i].res});
      check($sformatf("R%0d vec%0d flags", VECS[i].req, i), {24'd0, flg}, {24'd0, VECS[i].flg});
      check($sformatf("R12 vec%0d mask", i), {24'd0, msk}, {24'd0, VECS[i].msk});
      check($sformatf("R12 vec%0d we", i), {31'd0, we}, {31'd0, VECS[i].we});
    end

    // R6: compare never alters the accumulator for any value
    for (int v = 0; v < 256; v++) begin
      drive(4'd4, v[7:0], v[7:0] ^ 8'h5A, v[0], 1'b0);
      check("R6 cmp acc", {23'd0, we, res}, {24'd0, v[7:0]});
    end

    // R7: increment wraps and leaves CY unwritten whatever cy_i is
    for (int v = 0; v < 256; v++) begin
      drive(4'd5, v[7:0], 8'h00, 1'b1, 1'b0);
      check("R7 inc", {16'd0, msk, res}, {16'd0, 8'hD4, 8'(v + 1)});
    end

    // R1: unused flag positions stay clear across every operation code
    for (int o = 0; o < 16; o++) begin
      drive(o[3:0], 8'hFF, 8'hFF, 1'b1, 1'b1);
      check("R1 unused bits", {24'd0, (flg | msk) & 8'h2A}, 32'h0);
    end

    finish_run();
  end
endmodule